// File: doc/BRIEF.md
# Nine-Operand Carry-Save Summing Unit

This unit adds nine unsigned operands of a common, configurable width and returns their exact total. It works in two phases. First, a fixed tree of 3:2 carry-save cells brings the operand count down from nine to six, then four, then three, then two. Each cell computes every bit position on its own, with no carry passing between neighbours. Second, a single carry-lookahead adder turns the last two vectors into one binary result.

The result is the operand width plus four bits. That is wide enough for nine maximal operands, so the result never overflows. A parameter chooses between two forms. In the pipelined form, each compressor level and the final adder end in a register, and the valid strobe travels with the data. In the combinational form, the result and valid appear in the same cycle as the inputs.

Typical uses are accumulating partial products or summing a window of samples. In these cases a set of nine values arrives together and only their total is needed.

Top module: `csa_sum9`

## Requirements
- R1: `sum_out` equals the exact arithmetic sum of `opd0`..`opd8` read as unsigned numbers, in `W+4` bits, for any operand values.
- R2: Each compressor level keeps the total of its vectors unchanged modulo 2^(W+4). The sum word of a cell is the XOR of its three inputs. The carry word is their bitwise majority, moved up one bit position.
- R3: Reduction runs through exactly four compressor levels, with operand counts 9, 6, 4, 3 and 2. At a level where the count is not a multiple of three, the leftover operand is passed through unchanged.
- R4: The final adder produces the exact sum of its two input vectors. Each of its carries is formed from the generate and propagate terms of all lower bits.
- R5: With `PIPE=1`, a set of operands presented with `in_vld=1` before clock edge k appears on `sum_out` with `out_vld=1` after edge k+4, which is five edges in total. With `PIPE=0`, `sum_out` and `out_vld` follow the inputs in the same cycle.
- R6: All-zero operands give 0. All operands at 2^W-1 give 9*(2^W-1), which is 2295 for W=8.
- R7: With `PIPE=1`, while `rst_n` is low, `out_vld` and `sum_out` are 0.
- R8: With `PIPE=1`, a new operand set may be presented every cycle, and gaps in `in_vld` are allowed. Each valid set yields exactly one valid result, in the order the sets were presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand set valid |
| opd0 | input | W | Operand 0 |
| opd1 | input | W | Operand 1 |
| opd2 | input | W | Operand 2 |
| opd3 | input | W | Operand 3 |
| opd4 | input | W | Operand 4 |
| opd5 | input | W | Operand 5 |
| opd6 | input | W | Operand 6 |
| opd7 | input | W | Operand 7 |
| opd8 | input | W | Operand 8 |
| sum_out | output | W+4 | Total of the nine operands |
| out_vld | output | 1 | Result valid |

## Verification
The hardest case to reach is the one where carries, moved up by each level, pile up in the top bits of the internal vectors. Only then does the final lookahead adder have to resolve long propagate runs, and only then does a wrong carry weight or a truncated vector show at the ports. The stimulus reaches it with operand sets that are all maximal, all at the top bit, and alternating bit patterns. A run of random sets then follows, streamed back-to-back with occasional gaps in valid. Every set is also sent, unchanged, through a combinational instance so that it can be compared in the same cycle.

// File: rtl/csa_pkg.sv
package csa_pkg;

    localparam int NUM_OPS   = 9;
    localparam int GROW_BITS = 4;
    localparam int NUM_LVLS  = 4;

    // operand count left after one 3:2 level
    function automatic int level_out(input int n);
        return 2 * (n / 3) + (n % 3);
    endfunction

endpackage

// File: rtl/csa_level.sv
module csa_level
    import csa_pkg::*;
#(
    parameter int RW    = 12,
    parameter int N_IN  = 9,
    parameter bit REG   = 1'b1,
    parameter int N_OUT = level_out(N_IN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       vin,
    input  logic [N_IN-1:0][RW-1:0]    din,
    output logic                       vout,
    output logic [N_OUT-1:0][RW-1:0]   dout
);

    localparam int NG = N_IN / 3;
    localparam int NL = N_IN % 3;

    logic [N_OUT-1:0][RW-1:0] nxt;

    // 3:2 cells, each bit position independent
    for (genvar g = 0; g < NG; g++) begin : g_cell
        logic [RW-1:0] x, y, z, maj;
        assign x   = din[3*g];
        assign y   = din[3*g+1];
        assign z   = din[3*g+2];
        assign maj = (x & y) | (x & z) | (y & z);
        assign nxt[2*g]   = x ^ y ^ z;
        assign nxt[2*g+1] = {maj[RW-2:0], 1'b0};
    end

    // leftover operands pass straight through
    for (genvar l = 0; l < NL; l++) begin : g_pass
        assign nxt[2*NG+l] = din[3*NG+l];
    end

    if (REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vout <= 1'b0;
                dout <= '0;
            end else begin
                vout <= vin;
                dout <= nxt;
            end
        end

        a_r5_stage_valid: assert property (@(posedge clk) disable iff (!rst_n)
            vout == $past(vin));
    end else begin : g_comb
        assign vout = vin;
        assign dout = nxt;
    end

    // total across the level is conserved (modulo 2^RW)
    logic [RW-1:0] tot_in, tot_nxt;
    always_comb begin
        tot_in  = '0;
        tot_nxt = '0;
        for (int i = 0; i < N_IN; i++)  tot_in  = tot_in + din[i];
        for (int i = 0; i < N_OUT; i++) tot_nxt = tot_nxt + nxt[i];
    end

    a_r2_level_conserves: assert property (@(posedge clk) disable iff (!rst_n)
        vin |-> (tot_nxt == tot_in));

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
    parameter int RW  = 12,
    parameter bit REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vin,
    input  logic [RW-1:0] a,
    input  logic [RW-1:0] b,
    output logic          vout,
    output logic [RW-1:0] s
);

    logic [RW-1:0] gen, prp, cry, sum_c;

    // every carry is built directly from lower generate/propagate terms
    always_comb begin
        gen = a & b;
        prp = a ^ b;
        cry = '0;
        for (int i = 1; i < RW; i++) begin
            for (int j = 0; j < i; j++) begin
                automatic logic term = gen[j];
                for (int k = j + 1; k < i; k++) term = term & prp[k];
                cry[i] = cry[i] | term;
            end
        end
        sum_c = prp ^ cry;
    end

    if (REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vout <= 1'b0;
                s    <= '0;
            end else begin
                vout <= vin;
                s    <= sum_c;
            end
        end
    end else begin : g_comb
        assign vout = vin;
        assign s    = sum_c;
    end

    a_r4_adder_exact: assert property (@(posedge clk) disable iff (!rst_n)
        vin |-> (sum_c == RW'(a + b)));

endmodule

// File: rtl/csa_sum9.sv
module csa_sum9
    import csa_pkg::*;
#(
    parameter int W    = 8,
    parameter bit PIPE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [W-1:0]     opd0,
    input  logic [W-1:0]     opd1,
    input  logic [W-1:0]     opd2,
    input  logic [W-1:0]     opd3,
    input  logic [W-1:0]     opd4,
    input  logic [W-1:0]     opd5,
    input  logic [W-1:0]     opd6,
    input  logic [W-1:0]     opd7,
    input  logic [W-1:0]     opd8,
    output logic [W+3:0]     sum_out,
    output logic             out_vld
);

    localparam int RW = W + GROW_BITS;
    localparam int N0 = NUM_OPS;
    localparam int N1 = level_out(N0);
    localparam int N2 = level_out(N1);
    localparam int N3 = level_out(N2);
    localparam int N4 = level_out(N3);
    localparam int LAT = NUM_LVLS + 1;
    localparam logic [RW-1:0] MAX_SUM = RW'(NUM_OPS * ((2 ** W) - 1));

    logic [N0-1:0][RW-1:0] v0;
    logic [N1-1:0][RW-1:0] v1;
    logic [N2-1:0][RW-1:0] v2;
    logic [N3-1:0][RW-1:0] v3;
    logic [N4-1:0][RW-1:0] v4;
    logic vl1, vl2, vl3, vl4;

    assign v0 = {RW'(opd8), RW'(opd7), RW'(opd6), RW'(opd5), RW'(opd4),
                 RW'(opd3), RW'(opd2), RW'(opd1), RW'(opd0)};

    csa_level #(.RW(RW), .N_IN(N0), .REG(PIPE)) u_lvl1 (
        .clk(clk), .rst_n(rst_n), .vin(in_vld), .din(v0), .vout(vl1), .dout(v1));
    csa_level #(.RW(RW), .N_IN(N1), .REG(PIPE)) u_lvl2 (
        .clk(clk), .rst_n(rst_n), .vin(vl1), .din(v1), .vout(vl2), .dout(v2));
    csa_level #(.RW(RW), .N_IN(N2), .REG(PIPE)) u_lvl3 (
        .clk(clk), .rst_n(rst_n), .vin(vl2), .din(v2), .vout(vl3), .dout(v3));
    csa_level #(.RW(RW), .N_IN(N3), .REG(PIPE)) u_lvl4 (
        .clk(clk), .rst_n(rst_n), .vin(vl3), .din(v3), .vout(vl4), .dout(v4));

    cla_adder #(.RW(RW), .REG(PIPE)) u_cla (
        .clk(clk), .rst_n(rst_n), .vin(vl4), .a(v4[0]), .b(v4[1]),
        .vout(out_vld), .s(sum_out));

    // R3: the tree ends in exactly two vectors
    initial begin
        a_r3_two_vectors: assert (N4 == 2);
    end

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (sum_out <= MAX_SUM));

    if (PIPE) begin : g_lat
        a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld == $past(in_vld, LAT));
    end

endmodule

// File: tb/sim_csa_sum9.sv
`timescale 1ns/1ps
module sim_csa_sum9;

    localparam int W  = 8;
    localparam int RW = W + 4;
    localparam int NT = 8;

    localparam logic [7:0] TBL [NT][9] = '{
        '{8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0},
        '{8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255},
        '{8'd1,   8'd2,   8'd3,   8'd4,   8'd5,   8'd6,   8'd7,   8'd8,   8'd9},
        '{8'd128, 8'd128, 8'd128, 8'd128, 8'd128, 8'd128, 8'd128, 8'd128, 8'd128},
        '{8'd255, 8'd0,   8'd255, 8'd0,   8'd255, 8'd0,   8'd255, 8'd0,   8'd255},
        '{8'd1,   8'd2,   8'd4,   8'd8,   8'd16,  8'd32,  8'd64,  8'd128, 8'd255},
        '{8'd100, 8'd200, 8'd50,  8'd25,  8'd75,  8'd150, 8'd250, 8'd5,   8'd10},
        '{8'd170, 8'd85,  8'd170, 8'd85,  8'd170, 8'd85,  8'd170, 8'd85,  8'd170}
    };
    localparam int TBL_EXP [NT] = '{0, 2295, 45, 1152, 1275, 510, 865, 1190};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0;
    logic [W-1:0] opv [9];
    logic [RW-1:0] sum_p, sum_c;
    logic vld_p, vld_c;

    int checks = 0;
    int fails  = 0;
    int exp_q [256];
    int wr_i = 0;
    int rd_i = 0;

    always #10 clk = ~clk;

    csa_sum9 #(.W(W), .PIPE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .opd0(opv[0]), .opd1(opv[1]), .opd2(opv[2]), .opd3(opv[3]), .opd4(opv[4]),
        .opd5(opv[5]), .opd6(opv[6]), .opd7(opv[7]), .opd8(opv[8]),
        .sum_out(sum_p), .out_vld(vld_p));

    csa_sum9 #(.W(W), .PIPE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .opd0(opv[0]), .opd1(opv[1]), .opd2(opv[2]), .opd3(opv[3]), .opd4(opv[4]),
        .opd5(opv[5]), .opd6(opv[6]), .opd7(opv[7]), .opd8(opv[8]),
        .sum_out(sum_c), .out_vld(vld_c));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_sum();
        int t = 0;
        for (int i = 0; i < 9; i++) t += int'(opv[i]);
        return t;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // pipelined output: compare against scoreboard when valid
    task automatic check_pipe();
        if (vld_p) begin
            if (rd_i < wr_i) begin
                chk(int'(sum_p) == exp_q[rd_i % 256], "R1/R8 pipelined sum", int'(sum_p), exp_q[rd_i % 256]);
                rd_i++;
            end else begin
                chk(1'b0, "R8 unexpected valid", 1, 0);
            end
        end
    endtask

    task automatic drive(input int e);
        in_vld = 1'b1;
        exp_q[wr_i % 256] = e;
        wr_i++;
        #1;
        chk(vld_c == 1'b1, "R5 comb valid", int'(vld_c), 1);
        chk(int'(sum_c) == e, "R1 comb sum", int'(sum_c), e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        for (int i = 0; i < 9; i++) opv[i] = '0;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(vld_p == 1'b0, "R7 reset valid", int'(vld_p), 0);
        chk(sum_p == '0, "R7 reset sum", int'(sum_p), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 / R3: single set, five register stages (four levels plus adder)
        for (int i = 0; i < 9; i++) opv[i] = TBL[2][i];
        in_vld = 1'b1;
        #1;
        chk(int'(sum_c) == 45 && vld_c, "R5 comb same-cycle", int'(sum_c), 45);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (k == 1) in_vld = 1'b0;
            if (k == 4) chk(vld_p == 1'b0, "R5 R3 not yet valid at edge 4", int'(vld_p), 0);
            if (k == 5) begin
                chk(vld_p == 1'b1, "R5 R3 valid at edge 5", int'(vld_p), 1);
                chk(int'(sum_p) == 45, "R5 latency sum", int'(sum_p), 45);
            end
        end
        repeat (3) @(negedge clk);

        // table walk, back-to-back (R6 rows 0 and 1, R2 carry-heavy rows)
        for (int r = 0; r < NT; r++) begin
            check_pipe();
            for (int i = 0; i < 9; i++) opv[i] = TBL[r][i];
            chk(ref_sum() == TBL_EXP[r], "R6 table self", ref_sum(), TBL_EXP[r]);
            drive(TBL_EXP[r]);
            @(negedge clk);
        end

        // random stream with valid gaps (R8, R2)
        for (int n = 0; n < 60; n++) begin
            check_pipe();
            for (int i = 0; i < 9; i++) opv[i] = W'($urandom);
            if (n % 7 == 3) begin
                in_vld = 1'b0;
            end else begin
                drive(ref_sum());
            end
            @(negedge clk);
        end
        in_vld = 1'b0;
        for (int d = 0; d < 8; d++) begin
            check_pipe();
            @(negedge clk);
        end
        chk(rd_i == wr_i, "R8 one result per valid set", rd_i, wr_i);

        // R6: all-maximal directed, compare end result
        for (int i = 0; i < 9; i++) opv[i] = 8'hFF;
        drive(2295);
        @(negedge clk);
        in_vld = 1'b0;
        repeat (4) @(negedge clk);
        check_pipe();
        chk(rd_i == wr_i, "R6 max result seen", rd_i, wr_i);

        summary();
    end

endmodule